// File: doc/BRIEF.md
# Output-Compare Timer

A 16-bit timer peripheral for periodic interrupts. A free-running counter advances on ticks from a power-of-two prescaler and is never reloaded. When it reaches its top value it rolls over to zero and raises an overflow flag. One compare channel raises its own flag when the counter steps onto the value held in a compare register. Both flags are cleared by writing a 1 to them, and each flag has an enable that routes it to a single interrupt request line.

Software gets a fixed period by adding a constant to the compare register after each match. The sum is taken modulo 65536, so a compare value that rolls past the top still fires after exactly the intended number of ticks. The overflow flag serves as an extension for intervals longer than one full counter cycle. Registers are reached through a single-cycle synchronous write port with a combinational read port.

Top module: `ocmp_timer`

Register map (3-bit address): 0 control (bit 7 run enable), 1 prescale (bit 7 overflow interrupt enable, bits 2:0 prescale select), 2 channel mode (bit 0 selects compare), 3 channel interrupt enable (bit 0), 4 compare value, 5 counter, 6 compare flag (bit 0), 7 overflow flag (bit 7). Bits not listed read as 0.

## Requirements
- R1: After reset every register reads 0, the counter is 0 and irq_o is low.
- R2: The counter advances by one on each prescaler tick, only while run enable (address 0 bit 7) is 1. It holds its value while that bit is 0, and it wraps from 0xFFFF to 0x0000.
- R3: A prescale select value n (address 1 bits 2:0) gives one counter advance per 2^n bus clocks. n = 0 advances the counter on every clock.
- R4: The overflow flag (address 7 bit 7) is set on the clock edge at which the counter wraps to 0x0000.
- R5: The compare flag (address 6 bit 0) is set on the edge at which the counter advances onto the compare value. This happens only while the channel mode bit (address 2 bit 0) is 1.
- R6: A match is evaluated only when the counter advances. While the counter holds a value equal to the compare value, a cleared compare flag stays clear.
- R7: The match is a 16-bit equality test. A compare value set D ticks ahead modulo 65536 matches after exactly D ticks, even across the counter wrap.
- R8: Writing 1 to a flag bit clears that flag, and writing 0 leaves it unchanged.
- R9: If a flag is set and cleared on the same edge, it ends up set.
- R10: irq_o is high when the overflow flag and its enable (address 1 bit 7) are both 1, or when the compare flag and its enable (address 3 bit 0) are both 1.
- R11: Reading address 5 returns the live counter. Writes to address 5 are ignored.
- R12: A compare-value write applies from the next counter advance on. An advance on the same edge as the write uses the previous compare value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Bus clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| bus_we_i | input | 1 | Write strobe, one write per asserted cycle |
| bus_addr_i | input | 3 | Register address |
| bus_wdata_i | input | 16 | Write data |
| bus_rdata_o | output | 16 | Read data for bus_addr_i, combinational |
| irq_o | output | 1 | Combined interrupt request |

## Verification
A write lands on the rising edge that ends its cycle, and a read reflects state in the same cycle. A counter advance, and any flag it raises, is visible in the cycle after the edge that caused it. The interrupt line follows a flag or an enable within that same cycle. The bench counts rising edges and turns each requirement into an exact target count: the counter at edge t0+k must read c0+k (or c0+k/2^n under prescaling), and each flag must still be clear one edge before its event and set at it. Each sample is taken at the falling edge that carries that count.

// File: rtl/ocmp_timer_pkg.sv
package ocmp_timer_pkg;
  typedef enum logic [2:0] {
    REG_CTRL  = 3'd0,
    REG_PRESC = 3'd1,
    REG_MODE  = 3'd2,
    REG_CHIE  = 3'd3,
    REG_CMP   = 3'd4,
    REG_CNT   = 3'd5,
    REG_CFLG  = 3'd6,
    REG_OFLG  = 3'd7
  } reg_addr_e;

  localparam int unsigned RUN_BIT    = 7;
  localparam int unsigned OVF_IE_BIT = 7;
  localparam int unsigned OVF_FL_BIT = 7;
  localparam int unsigned CH_BIT     = 0;
endpackage

// File: rtl/ocmp_prescaler.sv
module ocmp_prescaler #(
  parameter int unsigned SEL_W = 3
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             en_i,
  input  logic [SEL_W-1:0] sel_i,
  output logic             tick_o
);
  localparam int unsigned DIV_W = (1 << SEL_W) - 1;

  logic [DIV_W-1:0] div_q;
  logic [DIV_W-1:0] mask;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    div_q <= '0;
    else if (!en_i) div_q <= '0;
    else            div_q <= div_q + DIV_W'(1);
  end

  always_comb begin
    for (int i = 0; i < DIV_W; i++) mask[i] = (i < int'(sel_i));
  end

  assign tick_o = en_i && ((div_q & mask) == mask);
endmodule

// File: rtl/ocmp_counter.sv
module ocmp_counter #(
  parameter int unsigned CNT_W = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             tick_i,
  input  logic             clr_i,
  output logic [CNT_W-1:0] cnt_o,
  output logic             ovf_o
);
  logic [CNT_W-1:0] cnt_q;
  logic             ovf_q;
  logic             wrap;

  assign wrap = tick_i && (&cnt_q);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
      ovf_q <= 1'b0;
    end else begin
      if (tick_i) cnt_q <= cnt_q + CNT_W'(1);
      ovf_q <= wrap | (ovf_q & ~clr_i);  // set wins
    end
  end

  assign cnt_o = cnt_q;
  assign ovf_o = ovf_q;

  a_r4_ovf_on_wrap: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tick_i && (&cnt_q)) |=> (ovf_q && cnt_q == '0));
  a_r2_hold_without_tick: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !tick_i |=> $stable(cnt_q));
endmodule

// File: rtl/ocmp_channel.sv
module ocmp_channel #(
  parameter int unsigned CNT_W = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             tick_i,
  input  logic [CNT_W-1:0] cnt_i,
  input  logic [CNT_W-1:0] cmp_i,
  input  logic             oc_sel_i,
  input  logic             clr_i,
  output logic             flag_o
);
  logic [CNT_W-1:0] cnt_nxt;
  logic             hit;
  logic             flag_q;

  // compare against the value the counter is about to take
  assign cnt_nxt = cnt_i + CNT_W'(1);
  assign hit     = tick_i && oc_sel_i && (cnt_nxt == cmp_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) flag_q <= 1'b0;
    else         flag_q <= hit | (flag_q & ~clr_i);
  end

  assign flag_o = flag_q;

  a_r6_no_match_on_stall: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !tick_i |=> !$rose(flag_q));
  a_r5_mode_gates_match: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !oc_sel_i |=> !$rose(flag_q));
endmodule

// File: rtl/ocmp_timer.sv
module ocmp_timer
  import ocmp_timer_pkg::*;
#(
  parameter int unsigned CNT_W = 16,
  parameter int unsigned SEL_W = 3
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             bus_we_i,
  input  logic [2:0]       bus_addr_i,
  input  logic [CNT_W-1:0] bus_wdata_i,
  output logic [CNT_W-1:0] bus_rdata_o,
  output logic             irq_o
);
  logic             run_q, ovf_ie_q, oc_sel_q, ch_ie_q;
  logic [SEL_W-1:0] sel_q;
  logic [CNT_W-1:0] cmp_q;
  logic [CNT_W-1:0] cnt_w;
  logic             tick_w, ovf_w, cflag_w;
  logic             wr_ctrl, wr_presc, wr_mode, wr_chie, wr_cmp;
  logic             cclr, oclr;

  assign wr_ctrl  = bus_we_i && (bus_addr_i == REG_CTRL);
  assign wr_presc = bus_we_i && (bus_addr_i == REG_PRESC);
  assign wr_mode  = bus_we_i && (bus_addr_i == REG_MODE);
  assign wr_chie  = bus_we_i && (bus_addr_i == REG_CHIE);
  assign wr_cmp   = bus_we_i && (bus_addr_i == REG_CMP);
  assign cclr     = bus_we_i && (bus_addr_i == REG_CFLG) && bus_wdata_i[CH_BIT];
  assign oclr     = bus_we_i && (bus_addr_i == REG_OFLG) && bus_wdata_i[OVF_FL_BIT];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      run_q    <= 1'b0;
      ovf_ie_q <= 1'b0;
      sel_q    <= '0;
      oc_sel_q <= 1'b0;
      ch_ie_q  <= 1'b0;
      cmp_q    <= '0;
    end else begin
      if (wr_ctrl) run_q <= bus_wdata_i[RUN_BIT];
      if (wr_presc) begin
        ovf_ie_q <= bus_wdata_i[OVF_IE_BIT];
        sel_q    <= bus_wdata_i[SEL_W-1:0];
      end
      if (wr_mode) oc_sel_q <= bus_wdata_i[CH_BIT];
      if (wr_chie) ch_ie_q  <= bus_wdata_i[CH_BIT];
      if (wr_cmp)  cmp_q    <= bus_wdata_i;
    end
  end

  ocmp_prescaler #(.SEL_W(SEL_W)) i_presc (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .en_i  (run_q),
    .sel_i (sel_q),
    .tick_o(tick_w)
  );

  ocmp_counter #(.CNT_W(CNT_W)) i_cnt (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .tick_i(tick_w),
    .clr_i (oclr),
    .cnt_o (cnt_w),
    .ovf_o (ovf_w)
  );

  ocmp_channel #(.CNT_W(CNT_W)) i_ch0 (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .tick_i  (tick_w),
    .cnt_i   (cnt_w),
    .cmp_i   (cmp_q),
    .oc_sel_i(oc_sel_q),
    .clr_i   (cclr),
    .flag_o  (cflag_w)
  );

  always_comb begin
    bus_rdata_o = '0;
    unique case (reg_addr_e'(bus_addr_i))
      REG_CTRL:  bus_rdata_o[RUN_BIT] = run_q;
      REG_PRESC: begin
        bus_rdata_o[OVF_IE_BIT]  = ovf_ie_q;
        bus_rdata_o[SEL_W-1:0]   = sel_q;
      end
      REG_MODE:  bus_rdata_o[CH_BIT] = oc_sel_q;
      REG_CHIE:  bus_rdata_o[CH_BIT] = ch_ie_q;
      REG_CMP:   bus_rdata_o = cmp_q;
      REG_CNT:   bus_rdata_o = cnt_w;
      REG_CFLG:  bus_rdata_o[CH_BIT] = cflag_w;
      REG_OFLG:  bus_rdata_o[OVF_FL_BIT] = ovf_w;
      default:   bus_rdata_o = '0;
    endcase
  end

  assign irq_o = (ovf_w & ovf_ie_q) | (cflag_w & ch_ie_q);

  a_r3_div1_every_clock: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (run_q && sel_q == '0) |=> (cnt_w == CNT_W'($past(cnt_w) + CNT_W'(1))));
  a_r2_stopped_holds: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !run_q |=> $stable(cnt_w));
  a_r9_set_beats_clear: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tick_w && oc_sel_q && cclr && (CNT_W'(cnt_w + CNT_W'(1)) == cmp_q)) |=> cflag_w);
endmodule

// File: tb/test_ocmp_timer.sv
module test_ocmp_timer;
  import ocmp_timer_pkg::*;

  localparam int CLK_PERIOD = 10;
  localparam int IRQ_KIND   = 8;

  typedef struct {
    int    kind;
    int    exp;
    string req;
  } item_t;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        we = 1'b0;
  logic [2:0]  addr = '0;
  logic [15:0] wdata = '0;
  logic [15:0] rdata;
  logic        irq;

  int total = 0;
  int bad   = 0;
  int cyc   = 0;
  bit done  = 1'b0;
  item_t q[$];

  ocmp_timer i_ocmp_timer (
    .clk_i      (clk),
    .rst_ni     (rst_n),
    .bus_we_i   (we),
    .bus_addr_i (addr),
    .bus_wdata_i(wdata),
    .bus_rdata_o(rdata),
    .irq_o      (irq)
  );

  always #(CLK_PERIOD / 2) clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  // monitor: pops expected items and compares mid-cycle
  initial begin
    forever begin
      @(negedge clk);
      #1;
      while (q.size() > 0) begin
        item_t it;
        int got;
        it  = q.pop_front();
        got = (it.kind == IRQ_KIND) ? int'(irq) : int'(rdata);
        total++;
        if (got != it.exp) begin
          bad++;
          $display("FAIL %s kind=%0d got=0x%0h exp=0x%0h @cyc %0d", it.req, it.kind, got, it.exp, cyc);
        end
      end
    end
  end

  task automatic push_chk(input int kind, input int exp, input string req);
    item_t it;
    it.kind = kind; it.exp = exp; it.req = req;
    if (kind != IRQ_KIND) addr = 3'(kind);
    q.push_back(it);
    #2;
  endtask

  task automatic chk(input int kind, input int exp, input string req);
    @(negedge clk);
    push_chk(kind, exp, req);
  endtask

  task automatic chk_at(input int n, input int kind, input int exp, input string req);
    @(negedge clk);
    while (cyc < n) @(negedge clk);
    push_chk(kind, exp, req);
  endtask

  task automatic wr(input int a, input int d);
    @(negedge clk);
    we = 1'b1; addr = 3'(a); wdata = 16'(d);
    @(negedge clk);
    we = 1'b0;
  endtask

  task automatic wr_at(input int n, input int a, input int d);
    @(negedge clk);
    while (cyc < n - 1) @(negedge clk);
    we = 1'b1; addr = 3'(a); wdata = 16'(d);
    @(negedge clk);
    we = 1'b0;
  endtask

  task automatic peek(input int a, output int v, output int t);
    @(negedge clk);
    addr = 3'(a);
    #1;
    v = int'(rdata);
    t = cyc;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog expired got=running exp=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    int c0, t0, v, d;
    int cnt_a, cfl_a, ofl_a;
    cnt_a = int'(REG_CNT);
    cfl_a = int'(REG_CFLG);
    ofl_a = int'(REG_OFLG);

    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R1 reset state
    for (int a = 0; a < 8; a++) chk(a, 0, "R1");
    chk(IRQ_KIND, 0, "R1");

    // R11 counter writes ignored, R2 hold while stopped
    wr(cnt_a, 16'h1234);
    repeat (5) @(negedge clk);
    chk(cnt_a, 0, "R11 R2");

    // R2 R3 divide-by-1
    wr(int'(REG_CTRL), 16'h0080);
    peek(cnt_a, c0, t0);
    chk_at(t0 + 1, cnt_a, c0 + 1, "R3");
    chk_at(t0 + 10, cnt_a, c0 + 10, "R2");

    // R3 divide-by-4 and divide-by-128
    wr(int'(REG_PRESC), 16'h0002);
    peek(cnt_a, c0, t0);
    chk_at(t0 + 16, cnt_a, c0 + 4, "R3");
    wr(int'(REG_PRESC), 16'h0007);
    peek(cnt_a, c0, t0);
    chk_at(t0 + 256, cnt_a, c0 + 2, "R3");

    // R6 no re-match while prescaler stalls the counter
    wr(int'(REG_MODE), 16'h0001);
    peek(cnt_a, c0, t0);
    wr(int'(REG_CMP), c0 + 2);
    v = 0;
    for (int i = 0; i < 400 && v == 0; i++) peek(cfl_a, v, t0);
    chk(cfl_a, 1, "R6");
    wr(cfl_a, 16'h0001);
    repeat (50) @(negedge clk);
    chk(cfl_a, 0, "R6");
    chk(cnt_a, c0 + 2, "R6");

    // R2 stopped counter holds
    wr(int'(REG_CTRL), 16'h0000);
    peek(cnt_a, c0, t0);
    chk_at(t0 + 20, cnt_a, c0, "R2");

    // R5 mode gate, then match
    wr(int'(REG_PRESC), 16'h0000);
    wr(int'(REG_CTRL), 16'h0080);
    wr(int'(REG_MODE), 16'h0000);
    peek(cnt_a, c0, t0);
    wr(int'(REG_CMP), c0 + 20);
    chk_at(t0 + 25, cfl_a, 0, "R5");
    wr(int'(REG_MODE), 16'h0001);
    peek(cnt_a, c0, t0);
    wr(int'(REG_CMP), c0 + 20);
    chk_at(t0 + 19, cfl_a, 0, "R5");
    chk_at(t0 + 20, cfl_a, 1, "R5");
    chk(IRQ_KIND, 0, "R10");
    wr(int'(REG_CHIE), 16'h0001);
    chk(IRQ_KIND, 1, "R10");
    wr(cfl_a, 16'h0000);
    chk(cfl_a, 1, "R8");
    wr(cfl_a, 16'h0001);
    chk(cfl_a, 0, "R8");
    chk(IRQ_KIND, 0, "R10");

    // R12 write on the same edge as the advance uses old value
    peek(cnt_a, c0, t0);
    wr_at(t0 + 10, int'(REG_CMP), c0 + 10);
    chk_at(t0 + 12, cfl_a, 0, "R12");

    // R9 set beats a same-edge clear
    peek(cnt_a, c0, t0);
    wr(int'(REG_CMP), c0 + 30);
    wr_at(t0 + 30, cfl_a, 16'h0001);
    chk(cfl_a, 1, "R9");
    wr(cfl_a, 16'h0001);
    chk(cfl_a, 0, "R9");

    // R4 overflow and R7 compare wrapping past the top
    wr(int'(REG_PRESC), 16'h0080);
    peek(cnt_a, c0, t0);
    d = 65536 - c0 + 100;
    wr(int'(REG_CMP), (c0 + d) % 65536);
    chk_at(t0 + 65536 - c0 - 1, ofl_a, 0, "R4");
    chk_at(t0 + 65536 - c0, ofl_a, 16'h0080, "R4");
    chk_at(t0 + 65536 - c0 + 1, cnt_a, 1, "R2");
    chk(IRQ_KIND, 1, "R10");
    chk_at(t0 + d - 1, cfl_a, 0, "R7");
    chk_at(t0 + d, cfl_a, 1, "R7");
    wr(cfl_a, 16'h0001);
    wr(int'(REG_PRESC), 16'h0000);
    chk(IRQ_KIND, 0, "R10");
    wr(ofl_a, 16'h0000);
    chk(ofl_a, 16'h0080, "R8");
    wr(ofl_a, 16'h0080);
    chk(ofl_a, 0, "R8");

    repeat (2) @(negedge clk);
    done = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule